// File: doc/BRIEF.md
# Clustered Multiport Cipher Register File

This block is the register storage behind a four-lane cipher datapath. A single bank of 32 words, each 64 bits wide, is shared by four lane clusters. Every cluster owns three read ports and two write ports, so in one cycle the bank serves twelve reads and up to eight writes. Reads are combinational and always show the contents held before the current cycle's writes. Writes land at the rising clock edge.

Beside the word bank sits one 8-bit bit register that all clusters share. It holds single-bit state such as memory bits, feedback bits and clock-control bits. Each cluster may update any subset of its bits in a cycle through a per-bit mask. All clusters see the same read value.

Write conflicts are settled by a fixed priority. The number of a write port is cluster × 2 + port, and the higher number wins. A synchronous reset clears every word and the bit register. The ports are plain, without a valid/ready handshake. A read is always available and a write is never refused, so no back-pressure exists.

Top module: `cfrf_top`

## Requirements
- R1: While `rst` is high at a rising edge, every word and the bit register are cleared to zero. All reads return zero in the cycles after that edge.
- R2: A read of an address returns the value the word held before the current cycle. A write to that address in the same cycle becomes visible only in the next cycle.
- R3: Each of the twelve read ports returns the word at its own 5-bit address, whatever the other ports select. Read port r uses bits [r*5 +: 5] of `rd_addr` and bits [r*64 +: 64] of `rd_data`. Read port r belongs to cluster r/3.
- R4: Up to eight writes to distinct addresses in one cycle all take effect at the same edge. Write port p uses bit p of `wr_en`, bits [p*5 +: 5] of `wr_addr` and bits [p*64 +: 64] of `wr_data`, where p = cluster*2 + port.
- R5: When several enabled write ports name the same address, the port with the highest number p wins. A higher cluster therefore beats a lower one, and port 1 beats port 0 within a cluster.
- R6: A write port whose enable bit is low changes nothing, whatever its address and data. A word that no enabled port names keeps its value.
- R7: Cluster c updates bit b of the bit register only where `sb_mask[c*8+b]` is 1, taking the value of `sb_wdata[c*8+b]`. Bits with no mask set by any cluster hold their value.
- R8: When several clusters set the mask for the same bit in one cycle, the highest cluster number decides that bit. Each bit is settled on its own.
- R9: `sb_rdata` shows the bit register as it was before the current cycle's updates. The new value appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | input | 60 | Twelve 5-bit read addresses, port r at [r*5 +: 5] |
| rd_data | output | 768 | Twelve 64-bit read results, port r at [r*64 +: 64] |
| wr_en | input | 8 | Write enables, one per write port p = cluster*2 + port |
| wr_addr | input | 40 | Eight 5-bit write addresses, port p at [p*5 +: 5] |
| wr_data | input | 512 | Eight 64-bit write words, port p at [p*64 +: 64] |
| sb_mask | input | 32 | Per-cluster bit mask for the bit register, cluster c at [c*8 +: 8] |
| sb_wdata | input | 32 | Per-cluster bit values for the bit register, cluster c at [c*8 +: 8] |
| sb_rdata | output | 8 | Current bit register value, shared by all clusters |

## Verification
The bench builds the block with its default parameters: four clusters, three read ports and two write ports per cluster, 32 words of 64 bits, and an 8-bit bit register. With only 32 words, random addresses often hit the same word. Part of the traffic is also confined to four addresses. Together these make multi-port write conflicts and same-cycle read-after-write frequent. Random masks from all four clusters overlap on the eight bits often enough to exercise the per-bit priority.

// File: rtl/cfrf_pkg.sv
package cfrf_pkg;
  localparam int CFRF_CLUSTERS = 4;
  localparam int CFRF_RD_PER   = 3;
  localparam int CFRF_WR_PER   = 2;
  localparam int CFRF_ENTRIES  = 32;
  localparam int CFRF_WORD     = 64;
  localparam int CFRF_SBITS    = 8;

  // Flat port number: higher number carries higher write priority.
  function automatic int port_id(input int cluster, input int port, input int per_cluster);
    return cluster * per_cluster + port;
  endfunction
endpackage

// File: rtl/cfrf_wr_arb.sv
module cfrf_wr_arb #(
  parameter int NP    = 8,
  parameter int DEPTH = 32,
  parameter int W     = 64,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] we,
  input  logic [AW-1:0] wa [NP],
  input  logic [W-1:0]  wd [NP],
  output logic [DEPTH-1:0] ent_we,
  output logic [W-1:0]  ent_wd [DEPTH]
);
  logic [NP-1:0] hit   [DEPTH];
  logic [NP-1:0] grant [DEPTH];

  // Per entry: find every port aiming at it, keep only the highest one.
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      logic found;
      found    = 1'b0;
      grant[e] = '0;
      for (int p = 0; p < NP; p++) begin
        hit[e][p] = we[p] && (wa[p] == AW'(e));
      end
      for (int p = NP - 1; p >= 0; p--) begin
        if (hit[e][p] && !found) begin
          grant[e][p] = 1'b1;
          found       = 1'b1;
        end
      end
      ent_we[e] = found;
      ent_wd[e] = '0;
      for (int p = 0; p < NP; p++) begin
        ent_wd[e] = ent_wd[e] | (wd[p] & {W{grant[e][p]}});
      end
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      // R5: at most one port is granted per entry, and only a requesting one.
      assert_grant_single_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant[g]) && ((grant[g] & ~hit[g]) == '0));
    end
  endgenerate
endmodule

// File: rtl/cfrf_gpr_bank.sv
module cfrf_gpr_bank #(
  parameter int DEPTH = 32,
  parameter int W     = 64,
  parameter int AW    = 5,
  parameter int NR    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] ent_we,
  input  logic [W-1:0]     ent_wd [DEPTH],
  input  logic [AW-1:0]    rd_addr [NR],
  output logic [W-1:0]     rd_data [NR]
);
  logic [W-1:0] mem_q [DEPTH];
  logic         rst_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (ent_we[e]) mem_q[e] <= ent_wd[e];
      end
    end
  end

  // Reads see the pre-edge contents.
  generate
    for (genvar r = 0; r < NR; r++) begin : g_rd
      assign rd_data[r] = mem_q[rd_addr[r]];
    end
  endgenerate

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      for (int e = 0; e < DEPTH; e++) begin
        assert_bank_cleared_R1: assert (mem_q[e] == '0);
      end
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_hold
      // R6: an entry without a granted write keeps its word.
      assert_entry_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !ent_we[g] |=> $stable(mem_q[g]));
    end
  endgenerate
endmodule

// File: rtl/cfrf_sbit_reg.sv
module cfrf_sbit_reg #(
  parameter int NC = 4,
  parameter int SB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SB-1:0] mask [NC],
  input  logic [SB-1:0] din  [NC],
  output logic [SB-1:0] q
);
  logic [SB-1:0] nxt;
  logic [SB-1:0] any_mask;
  logic          rst_d;

  // Clusters applied in ascending order: the highest masked cluster settles each bit.
  always_comb begin
    nxt      = q;
    any_mask = '0;
    for (int c = 0; c < NC; c++) begin
      nxt      = (nxt & ~mask[c]) | (din[c] & mask[c]);
      any_mask = any_mask | mask[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_sbit_cleared_R1: assert (q == '0);
    end
  end

  generate
    for (genvar b = 0; b < SB; b++) begin : g_bit
      assert_sbit_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !any_mask[b] |=> $stable(q[b]));
      assert_sbit_top_cluster_R8: assert property (@(posedge clk) disable iff (rst)
        mask[NC-1][b] |=> (q[b] == $past(din[NC-1][b])));
    end
  endgenerate
endmodule

// File: rtl/cfrf_top.sv
module cfrf_top #(
  parameter int CLUSTERS = cfrf_pkg::CFRF_CLUSTERS,
  parameter int RD_PER   = cfrf_pkg::CFRF_RD_PER,
  parameter int WR_PER   = cfrf_pkg::CFRF_WR_PER,
  parameter int ENTRIES  = cfrf_pkg::CFRF_ENTRIES,
  parameter int WORD     = cfrf_pkg::CFRF_WORD,
  parameter int SBITS    = cfrf_pkg::CFRF_SBITS,
  localparam int AW = $clog2(ENTRIES),
  localparam int NR = CLUSTERS * RD_PER,
  localparam int NW = CLUSTERS * WR_PER
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NR*AW-1:0]       rd_addr,
  output logic [NR*WORD-1:0]     rd_data,
  input  logic [NW-1:0]          wr_en,
  input  logic [NW*AW-1:0]       wr_addr,
  input  logic [NW*WORD-1:0]     wr_data,
  input  logic [CLUSTERS*SBITS-1:0] sb_mask,
  input  logic [CLUSTERS*SBITS-1:0] sb_wdata,
  output logic [SBITS-1:0]       sb_rdata
);
  logic [AW-1:0]    ra_u [NR];
  logic [WORD-1:0]  rd_u [NR];
  logic [AW-1:0]    wa_u [NW];
  logic [WORD-1:0]  wd_u [NW];
  logic [ENTRIES-1:0] ent_we;
  logic [WORD-1:0]  ent_wd [ENTRIES];
  logic [SBITS-1:0] sm_u [CLUSTERS];
  logic [SBITS-1:0] sd_u [CLUSTERS];

  generate
    for (genvar c = 0; c < CLUSTERS; c++) begin : g_cl
      for (genvar k = 0; k < RD_PER; k++) begin : g_rp
        localparam int P = cfrf_pkg::port_id(c, k, RD_PER);
        assign ra_u[P] = rd_addr[P*AW +: AW];
        assign rd_data[P*WORD +: WORD] = rd_u[P];
      end
      for (genvar k = 0; k < WR_PER; k++) begin : g_wp
        localparam int P = cfrf_pkg::port_id(c, k, WR_PER);
        assign wa_u[P] = wr_addr[P*AW +: AW];
        assign wd_u[P] = wr_data[P*WORD +: WORD];
      end
      assign sm_u[c] = sb_mask[c*SBITS +: SBITS];
      assign sd_u[c] = sb_wdata[c*SBITS +: SBITS];
    end
  endgenerate

  cfrf_wr_arb #(.NP(NW), .DEPTH(ENTRIES), .W(WORD), .AW(AW)) u_arb (
    .clk(clk), .rst(rst), .we(wr_en), .wa(wa_u), .wd(wd_u),
    .ent_we(ent_we), .ent_wd(ent_wd)
  );

  cfrf_gpr_bank #(.DEPTH(ENTRIES), .W(WORD), .AW(AW), .NR(NR)) u_bank (
    .clk(clk), .rst(rst), .ent_we(ent_we), .ent_wd(ent_wd),
    .rd_addr(ra_u), .rd_data(rd_u)
  );

  cfrf_sbit_reg #(.NC(CLUSTERS), .SB(SBITS)) u_sbit (
    .clk(clk), .rst(rst), .mask(sm_u), .din(sd_u), .q(sb_rdata)
  );
endmodule

// File: tb/tb_cfrf_top.sv
module tb_cfrf_top;
  localparam int NC = 4, NE = 32, W = 64, SB = 8, AW = 5, NR = 12, NW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [AW-1:0] ra [NR];
  logic [NW-1:0] we;
  logic [AW-1:0] wa [NW];
  logic [W-1:0]  wd [NW];
  logic [SB-1:0] sm [NC];
  logic [SB-1:0] sd [NC];

  logic [NR*AW-1:0]  rd_addr;
  logic [NR*W-1:0]   rd_data;
  logic [NW*AW-1:0]  wr_addr;
  logic [NW*W-1:0]   wr_data;
  logic [NC*SB-1:0]  sb_mask, sb_wdata;
  logic [SB-1:0]     sb_rdata;

  always_comb begin
    for (int r = 0; r < NR; r++) rd_addr[r*AW +: AW] = ra[r];
    for (int p = 0; p < NW; p++) begin
      wr_addr[p*AW +: AW] = wa[p];
      wr_data[p*W +: W]   = wd[p];
    end
    for (int c = 0; c < NC; c++) begin
      sb_mask[c*SB +: SB]  = sm[c];
      sb_wdata[c*SB +: SB] = sd[c];
    end
  end

  cfrf_top dut (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(we), .wr_addr(wr_addr), .wr_data(wr_data),
    .sb_mask(sb_mask), .sb_wdata(sb_wdata), .sb_rdata(sb_rdata)
  );

  logic [W-1:0]  m [NE];
  logic [SB-1:0] msb;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic idle();
    we = '0;
    for (int r = 0; r < NR; r++) ra[r] = '0;
    for (int p = 0; p < NW; p++) begin wa[p] = '0; wd[p] = '0; end
    for (int c = 0; c < NC; c++) begin sm[c] = '0; sd[c] = '0; end
  endtask

  // Check outputs against the model, then advance the model and move to the next negedge.
  task automatic go(input string tag);
    #2;
    for (int r = 0; r < NR; r++) begin
      checks++;
      if (rd_data[r*W +: W] !== m[ra[r]]) begin
        errors++;
        $display("FAIL %s read port %0d addr %0d: got %h expected %h",
                 tag, r, ra[r], rd_data[r*W +: W], m[ra[r]]);
      end
    end
    checks++;
    if (sb_rdata !== msb) begin
      errors++;
      $display("FAIL %s bit register: got %h expected %h", tag, sb_rdata, msb);
    end
    if (rst) begin
      for (int e = 0; e < NE; e++) m[e] = '0;
      msb = '0;
    end else begin
      for (int p = 0; p < NW; p++) if (we[p]) m[wa[p]] = wd[p];
      for (int c = 0; c < NC; c++) msb = (msb & ~sm[c]) | (sd[c] & sm[c]);
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int e = 0; e < NE; e++) m[e] = '0;
    msb = '0;

    // R1: everything reads zero after reset
    for (int k = 0; k < 3; k++) begin
      for (int r = 0; r < NR; r++) ra[r] = AW'((k * NR + r) % NE);
      go("R1");
    end

    // R4: eight distinct writes in one cycle, then read back
    for (int p = 0; p < NW; p++) begin
      we[p] = 1'b1; wa[p] = AW'(p + 1); wd[p] = rnd64();
    end
    go("R4");
    idle();
    for (int r = 0; r < NR; r++) ra[r] = AW'((r % NW) + 1);
    go("R4");

    // R2: same-cycle read returns old value, new value next cycle
    we[0] = 1'b1; wa[0] = 5'd5; wd[0] = 64'hdead_beef_0123_4567;
    for (int r = 0; r < NR; r++) ra[r] = 5'd5;
    go("R2");
    idle();
    for (int r = 0; r < NR; r++) ra[r] = 5'd5;
    go("R2");

    // R5: all ports collide on one address, port 7 must win
    for (int p = 0; p < NW; p++) begin
      we[p] = 1'b1; wa[p] = 5'd9; wd[p] = {32'h0, 32'(p + 100)};
    end
    go("R5");
    idle();
    for (int r = 0; r < NR; r++) ra[r] = 5'd9;
    go("R5");
    // R5: cluster 2 both ports plus cluster 1 port 1, port 5 must win
    we[3] = 1'b1; wa[3] = 5'd10; wd[3] = 64'h3333;
    we[4] = 1'b1; wa[4] = 5'd10; wd[4] = 64'h4444;
    we[5] = 1'b1; wa[5] = 5'd10; wd[5] = 64'h5555;
    go("R5");
    idle();
    for (int r = 0; r < NR; r++) ra[r] = 5'd10;
    go("R5");

    // R6: disabled ports with live address and data change nothing
    for (int p = 0; p < NW; p++) begin wa[p] = 5'd9; wd[p] = rnd64(); end
    for (int r = 0; r < NR; r++) ra[r] = 5'd9;
    go("R6");
    go("R6");
    idle();

    // R7 and R9: masked update, old value visible during the update cycle
    sm[0] = 8'h0F; sd[0] = 8'hA5;
    go("R9");
    idle();
    go("R7");
    sm[1] = 8'h00; sd[1] = 8'hFF;
    go("R7");
    idle();

    // R8: overlapping masks resolve per bit to the highest cluster
    sm[0] = 8'hFF; sd[0] = 8'h00;
    sm[1] = 8'hF0; sd[1] = 8'hFF;
    sm[3] = 8'h3C; sd[3] = 8'h00;
    go("R8");
    idle();
    go("R8");
    for (int c = 0; c < NC; c++) begin sm[c] = 8'hFF; sd[c] = SB'(8'h11 * (c + 1)); end
    go("R8");
    idle();
    go("R8");

    // R3, R5, R7, R8: random traffic, half the time on a narrow address window
    for (int n = 0; n < 3000; n++) begin
      logic narrow;
      narrow = $urandom_range(0, 1) == 1;
      for (int r = 0; r < NR; r++)
        ra[r] = narrow ? AW'($urandom_range(0, 3)) : AW'($urandom);
      for (int p = 0; p < NW; p++) begin
        we[p] = ($urandom_range(0, 2) != 0);
        wa[p] = narrow ? AW'($urandom_range(0, 3)) : AW'($urandom);
        wd[p] = rnd64();
      end
      for (int c = 0; c < NC; c++) begin
        sm[c] = ($urandom_range(0, 3) == 0) ? 8'h00 : SB'($urandom);
        sd[c] = SB'($urandom);
      end
      go("R3");
    end

    // R1: reset in mid-run clears words and bit register
    rst = 1'b1;
    go("R1");
    rst = 1'b0;
    idle();
    for (int k = 0; k < 3; k++) begin
      for (int r = 0; r < NR; r++) ra[r] = AW'((k * NR + r) % NE);
      go("R1");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule